// File: doc/BRIEF.md
# Generation-Bit Event Queue

This block holds a circular queue of event numbers in a small power-of-two memory of 32-bit words. A producer (the interrupt router) appends 31-bit event numbers. A consumer pulls them back out in arrival order. No head or tail pointer is shared for validity. Each stored word carries a generation flag in its top bit, and the writer inverts that flag on every pass around the memory. The reader keeps its own expected polarity and inverts it each time its index wraps to zero. The reader takes a word as new only when the word's flag differs from that polarity.

Words are kept byte-swapped (big-endian) in storage, and the read path swaps them back. The writer also tracks the reader's index and phase so that it can refuse a write that would land on an unconsumed word. It can pulse a notify line for every accepted event. One event value, 2^24, stands for the inter-processor interrupt, and the read port flags it.

Top module: `gq_event_queue`

## Requirements
- R1: After reset `notify`, `overflow` and `rd_ack` are low, and the first read request is answered as empty.
- R2: A read request sampled on a rising edge is answered on that same edge: `rd_ack` is high for exactly one cycle afterwards. Events are returned in the order they were accepted.
- R3: A read request made when no unconsumed event is held is answered with `rd_ack`=1, `rd_empty`=1, `rd_event`=0 and `rd_ipi`=0. It consumes nothing.
- R4: An event accepted on a rising edge can be read by a request sampled on the next edge or later. A read sampled on the same edge as the write sees the queue as it stood before that write.
- R5: Order and content are kept across many wraps of the index, through at least six full passes of the memory.
- R6: When the queue holds DEPTH unconsumed events, a further write is dropped. `overflow` is high for one cycle after that edge and `notify` stays low. This holds even if a read is sampled on the same edge. A dropped event is never returned.
- R7: With `notify_all`=1, every accepted write raises `notify` for one cycle after its edge. With `notify_all`=0, no write raises `notify`.
- R8: A returned event equal to 2^24 (0x0100_0000) sets `rd_ipi`=1. Any other returned value gives `rd_ipi`=0.
- R9: All 31 bits of an event are returned unchanged, including 0 and 0x7FFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Append request from the router |
| wr_event | input | 31 | Event number to append |
| notify_all | input | 1 | Pulse notify for every accepted event |
| notify | output | 1 | One-cycle pulse per accepted event |
| overflow | output | 1 | One-cycle pulse when a write was dropped |
| rd_req | input | 1 | Consumer asks for the next event |
| rd_ack | output | 1 | Response present this cycle |
| rd_empty | output | 1 | Response says nothing was pending |
| rd_ipi | output | 1 | Returned event is the inter-processor value |
| rd_event | output | 31 | Returned event number |

## Verification
The most likely internal faults are a wrong generation stamp or a wrong reader polarity after a wrap. Either one makes the reader see stale words as new, or new words as empty. That shows up as a wrong or missing value at `rd_event` within one pass of the memory after the first wrap. The bench therefore runs several passes and compares every response against a reference model. A wrong fullness comparison shows up at once as a missing or spurious `overflow` pulse, or later as a duplicated or lost event. The bench therefore fills the queue to exactly DEPTH and writes at that boundary, with and without a read on the same edge.

// File: rtl/gq_pkg.sv
package gq_pkg;
    localparam int EVW = 31;
    localparam logic [EVW-1:0] IPI_EVENT = 31'h0100_0000;

    typedef struct packed {
        logic           gen;
        logic [EVW-1:0] num;
    } gq_entry_t;

    typedef struct packed {
        logic           ack;
        logic           empty;
        logic           ipi;
        logic [EVW-1:0] num;
    } gq_resp_t;

    // byte order swap between core order and stored big-endian order
    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/gq_store.sv
module gq_store
    import gq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  gq_entry_t       wentry,
    input  logic [AW-1:0]   raddr,
    output gq_entry_t       rentry
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= swap32(wentry);
        end
    end

    assign rentry = gq_entry_t'(swap32(mem[raddr]));
endmodule

// File: rtl/gq_writer.sv
module gq_writer
    import gq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_valid,
    input  logic [EVW-1:0]  wr_event,
    input  logic            notify_all,
    input  logic [AW-1:0]   rd_idx,
    input  logic            rd_phase,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output gq_entry_t       wentry,
    output logic            notify,
    output logic            overflow
);
    localparam logic [AW-1:0] MASK = AW'((1 << AW) - 1);

    logic [AW-1:0] widx;
    logic          wgen;
    logic          full;

    // full: same slot and writer is one pass ahead of reader
    always_comb begin
        full   = (widx == rd_idx) && (wgen == rd_phase);
        we     = wr_valid && !full;
        waddr  = widx;
        wentry = '{gen: wgen, num: wr_event};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            widx     <= '0;
            wgen     <= 1'b1;
            notify   <= 1'b0;
            overflow <= 1'b0;
        end else begin
            notify   <= we && notify_all;
            overflow <= wr_valid && full;
            if (we) begin
                widx <= (widx + 1'b1) & MASK;
                if (widx == MASK) wgen <= ~wgen;
            end
        end
    end
endmodule

// File: rtl/gq_reader.sv
module gq_reader
    import gq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_req,
    input  gq_entry_t       rentry,
    output logic [AW-1:0]   ridx,
    output logic            rphase,
    output gq_resp_t        resp
);
    localparam logic [AW-1:0] MASK = AW'((1 << AW) - 1);

    logic fresh;
    assign fresh = (rentry.gen != rphase);

    always_ff @(posedge clk) begin
        if (rst) begin
            ridx   <= '0;
            rphase <= 1'b0;
            resp   <= '0;
        end else begin
            resp <= '0;
            if (rd_req) begin
                resp.ack <= 1'b1;
                if (fresh) begin
                    resp.num <= rentry.num;
                    resp.ipi <= (rentry.num == IPI_EVENT);
                    ridx     <= (ridx + 1'b1) & MASK;
                    if (ridx == MASK) rphase <= ~rphase;
                end else begin
                    resp.empty <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gq_event_queue.sv
module gq_event_queue
    import gq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_valid,
    input  logic [30:0]     wr_event,
    input  logic            notify_all,
    output logic            notify,
    output logic            overflow,
    input  logic            rd_req,
    output logic            rd_ack,
    output logic            rd_empty,
    output logic            rd_ipi,
    output logic [30:0]     rd_event
);
    logic [AW-1:0] ridx, waddr;
    logic          rphase, we;
    gq_entry_t     wentry, rentry;
    gq_resp_t      resp;

    gq_writer #(.AW(AW)) u_wr (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_event(wr_event),
        .notify_all(notify_all), .rd_idx(ridx), .rd_phase(rphase),
        .we(we), .waddr(waddr), .wentry(wentry),
        .notify(notify), .overflow(overflow)
    );

    gq_store #(.AW(AW)) u_mem (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wentry(wentry),
        .raddr(ridx), .rentry(rentry)
    );

    gq_reader #(.AW(AW)) u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rentry(rentry),
        .ridx(ridx), .rphase(rphase), .resp(resp)
    );

    assign rd_ack   = resp.ack;
    assign rd_empty = resp.empty;
    assign rd_ipi   = resp.ipi;
    assign rd_event = resp.num;
endmodule

// File: rtl/gq_event_queue_chk.sv
module gq_event_queue_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic        notify_all,
    input logic        rd_req,
    input logic        notify,
    input logic        overflow,
    input logic        rd_ack,
    input logic        rd_empty,
    input logic        rd_ipi,
    input logic [30:0] rd_event
);
    // R2: every request answered on the next cycle, none otherwise
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_ack);
    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_ack);
    // R3: empty response carries no event
    a_r3_empty_clean: assert property (@(posedge clk) disable iff (rst)
        rd_empty |-> (rd_ack && rd_event == 31'd0 && !rd_ipi));
    // R6: a write either notifies or overflows, never both
    a_r6_excl: assert property (@(posedge clk) disable iff (rst)
        !(notify && overflow));
    a_r6_no_write_no_flag: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (!overflow && !notify));
    // R7: notify-all writes end in notify or overflow
    a_r7_notify: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && notify_all) |=> (notify || overflow));
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !notify_all |=> !notify);
    // R8: ipi flag only for the reserved value
    a_r8_ipi: assert property (@(posedge clk) disable iff (rst)
        rd_ipi |-> (rd_ack && !rd_empty && rd_event == 31'h0100_0000));
endmodule

bind gq_event_queue gq_event_queue_chk u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .notify_all(notify_all),
    .rd_req(rd_req), .notify(notify), .overflow(overflow), .rd_ack(rd_ack),
    .rd_empty(rd_empty), .rd_ipi(rd_ipi), .rd_event(rd_event)
);

// File: tb/tb_gq_event_queue.sv
module tb_gq_event_queue;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [30:0] wr_event = '0;
    logic        notify_all = 1'b1;
    logic        rd_req = 1'b0;
    logic        notify, overflow, rd_ack, rd_empty, rd_ipi;
    logic [30:0] rd_event;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [30:0] model_q[$];
    logic [31:0] resp_q[$];   // {empty, event}
    string       tag_q[$];

    always #5 clk = ~clk;

    gq_event_queue #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_event(wr_event),
        .notify_all(notify_all), .notify(notify), .overflow(overflow),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_empty(rd_empty),
        .rd_ipi(rd_ipi), .rd_event(rd_event)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compare every response against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done && rd_ack) begin
            if (resp_q.size() == 0) begin
                check("R2", "unexpected ack", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = resp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "empty", {31'd0, rd_empty}, {31'd0, e[31]});
                check(t, "event", {1'b0, rd_event}, {1'b0, e[30:0]});
                check("R8", "ipi", {31'd0, rd_ipi},
                      {31'd0, (!e[31] && e[30:0] == 31'h0100_0000)});
            end
        end
    end

    // one cycle of stimulus; model applies read before write
    task automatic step(input bit w, input logic [30:0] ev, input bit r,
                        input string tag);
        int occ;
        bit acc;
        occ = model_q.size();
        @(negedge clk);
        wr_valid = w;
        wr_event = ev;
        rd_req   = r;
        if (r) begin
            if (occ > 0) resp_q.push_back({1'b0, model_q.pop_front()});
            else         resp_q.push_back(32'h8000_0000);
            tag_q.push_back(tag);
        end
        acc = w && (occ < DEPTH);
        if (acc) model_q.push_back(ev);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_req   = 1'b0;
        check(w && !acc ? "R6" : "R7", "notify",
              {31'd0, notify}, {31'd0, acc && notify_all});
        check("R6", "overflow", {31'd0, overflow}, {31'd0, w && !acc});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "notify", {31'd0, notify}, 32'd0);
        check("R1", "overflow", {31'd0, overflow}, 32'd0);
        check("R1", "ack", {31'd0, rd_ack}, 32'd0);
        step(0, 0, 1, "R1");
        step(0, 0, 1, "R3");

        // R2: ordered return
        for (int i = 0; i < 5; i++) step(1, 31'(100 + i), 0, "R2");
        for (int i = 0; i < 5; i++) step(0, 0, 1, "R2");
        step(0, 0, 1, "R3");

        // R4: same-edge read sees pre-write state
        step(1, 31'h55, 1, "R4");
        step(0, 0, 1, "R4");

        // R6: fill to DEPTH, overflow, overflow with concurrent read
        for (int i = 0; i < DEPTH; i++) step(1, 31'(200 + i), 0, "R6");
        step(1, 31'h0bad, 0, "R6");
        step(1, 31'h0bad, 1, "R6");
        step(1, 31'h77, 0, "R6");
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, "R6");

        // R7: no notify when disabled
        notify_all = 1'b0;
        for (int i = 0; i < 3; i++) step(1, 31'(300 + i), 0, "R7");
        notify_all = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R7");

        // R8, R9: special values
        step(1, 31'h0100_0000, 0, "R8");
        step(1, 31'h00FF_FFFF, 0, "R8");
        step(1, 31'h7FFF_FFFF, 0, "R9");
        step(1, 31'h0, 0, "R9");
        step(1, 31'h0100_0001, 0, "R8");
        for (int i = 0; i < 5; i++) step(0, 0, 1, "R9");

        // R5: many wraps with a mixed pattern
        for (int i = 0; i < 240; i++) begin
            bit w, r;
            w = (i % 3) != 2;
            r = (i % 4) != 0 || (i > 200);
            step(w, 31'((i * 7919) ^ 31'h1234_567), r, "R5");
        end
        while (model_q.size() > 0) step(0, 0, 1, "R5");
        step(0, 0, 1, "R5");
        @(negedge clk);
        check("R2", "pending responses", resp_q.size(), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule